// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a bus master for the two-wire management interface that 10G PHYs expose under IEEE 802.3 Clause 45. Software programs it through a small 32-bit register window. It holds a PHY port address and a device (MMD) address in a control register. Three writes each launch one frame: a write to the address register sends an address frame, a write to the data register sends a write frame, and a control write with the read bit set sends a read frame. The management clock MDC is derived from the system clock by a programmable divider. MDIO is presented as a tri-state pair (output value plus output enable, with a separate input).

A typical access takes two frames. The first is an address frame that loads the target register number into the PHY. The second is a write or read frame that moves 16 data bits. The address frame is tracked by a busy flag in the status register. Write and read frames are tracked by a busy flag in the top bit of the data register. A read whose turnaround is not pulled low by the PHY is reported through a read-error flag, and the previously held data is kept.

Top module: `mdio45_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, including unmapped offsets such as 0x00. MDC is low and MDIO is released (output enable low). While no frame is in flight, MDC stays low and MDIO stays released.
- R2: The register window decodes byte offsets 0x30 status, 0x34 control, 0x38 data and 0x3C address. Status bits 15:8 hold the divider field and read back as written. Status bit 0 (address busy) and bit 1 (read error) cannot be written. Control keeps bits 4:0 (device address), 9:5 (port address), 10 (preamble off), 11, 14 and 15 (read); bits 12 and 13 read zero.
- R3: When no frame is busy, a write to the address register stores its low 16 bits and starts an address frame carrying them. Status bit 0 reads one for exactly 2·H·N system cycles, where N is 64 bits with preamble and 32 without.
- R4: A frame is, MSB first: 32 ones (omitted when control bit 10 is set), start bits 00, opcode (00 address, 01 write, 11 read), the 5-bit port address, the 5-bit device address, turnaround 10, and 16 payload bits. The master drives every bit of an address or write frame.
- R5: When no frame is busy, a write to the data register stores its low 16 bits and starts a write frame carrying them. Data bit 31 reads one for exactly 2·H·N cycles.
- R6: When no frame is busy, a control write with bit 15 set starts a read frame. Its port, device and preamble-off fields come from that same write. The master releases MDIO from the first turnaround bit to the end of the frame and samples MDIO while MDC rises. Data bit 31 is busy for 2·H·N cycles. Afterwards data bits 15:0 hold the 16 sampled bits and status bit 1 is zero.
- R7: If MDIO is high when sampled in the second turnaround bit of a read, status bit 1 reads one after the frame and data bits 15:0 keep their previous value. The next read that is acknowledged clears the flag.
- R8: H equals the divider field, or 1 when the field is zero. MDC has a period of 2·H system cycles, each frame starts with MDC low, and MDIO output and enable change only when MDC falls or at the frame's start.
- R9: While either busy flag is set, a write to the address register, a write to the data register, and a control write with bit 15 set are all ignored. The register keeps its old value and no further frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte offset for both register reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the register at reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; low means released |
| mdio_i | input | 1 | MDIO value seen on the wire |

## Verification
The bound checker watches, on every cycle, that MDIO value and enable hold still while MDC is high, that MDC and the driver are quiet whenever no busy flag is set, that the two busy flags are never set together, that an address frame always ends with MDC low, and that the read-error flag can only rise right after a read or write frame. The exact bit order of each frame type, the 2·H·N busy length for several divider values (zero included), the captured read value, the error path that keeps old data, and the rejection of start writes during a busy frame depend on the stimulus. Only the bench's scenarios show these, by recording every bit at the MDC rising edge and comparing against frames it builds from the requirements.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

    // Register window byte offsets
    localparam logic [5:0] OFS_STAT = 6'h30;
    localparam logic [5:0] OFS_CTRL = 6'h34;
    localparam logic [5:0] OFS_DATA = 6'h38;
    localparam logic [5:0] OFS_ADDR = 6'h3C;

    // Field positions
    localparam int unsigned STAT_BUSY_BIT = 0;
    localparam int unsigned STAT_ERR_BIT  = 1;
    localparam int unsigned STAT_DIV_LSB  = 8;
    localparam int unsigned CTL_MMD_LSB   = 0;
    localparam int unsigned CTL_PORT_LSB  = 5;
    localparam int unsigned CTL_NOPRE_BIT = 10;
    localparam int unsigned CTL_RD_BIT    = 15;
    localparam int unsigned DATA_BUSY_BIT = 31;
    localparam logic [15:0] CTL_KEEP_MASK = 16'hCFFF;

    // Frame body layout (bit index after preamble)
    localparam int unsigned FRAME_BITS = 32;
    localparam logic [4:0]  LAST_IDX   = 5'(FRAME_BITS - 1);
    localparam logic [4:0]  TA_IDX     = 5'd14;
    localparam logic [4:0]  ACK_IDX    = 5'd15;
    localparam logic [4:0]  DAT_IDX    = 5'd16;

    // Encoding equals the on-wire opcode
    typedef enum logic [1:0] {
        FK_ADDR  = 2'b00,
        FK_WRITE = 2'b01,
        FK_READ  = 2'b11
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        logic        no_pre;
        logic [4:0]  port;
        logic [4:0]  mmd;
        logic [15:0] payload;
    } frame_req_t;

    // Body of a frame, start bits first
    function automatic logic [31:0] build_word(frame_kind_e kind, logic [4:0] port,
                                               logic [4:0] mmd, logic [15:0] payload);
        return {2'b00, kind, port, mmd, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cfg,
    output logic             mdc,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             wrap;

    always_comb begin
        last   = (half_cfg == '0) ? '0 : half_cfg - 1'b1;
        wrap   = run && (cnt_q == last);
        rise_o = wrap && !mdc;
        fall_o = wrap && mdc;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio45_serdes.sv
module mdio45_serdes
    import mdio45_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  frame_req_t  req_i,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        mdio_i,
    output logic        active_o,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done_o,
    output logic [15:0] cap_data_o,
    output logic        cap_err_o
);
    localparam int unsigned PRE_W = $clog2(PRE_LEN + 1);

    logic             active_q;
    logic [PRE_W-1:0] pre_left_q;
    logic [4:0]       idx_q;
    logic [31:0]      sh_q;
    logic             is_rd_q;
    logic [15:0]      cap_q;
    logic             err_q;
    logic             in_pre;
    logic             last_bit;

    always_comb begin
        in_pre     = (pre_left_q != '0);
        last_bit   = !in_pre && (idx_q == LAST_IDX);
        done_o     = active_q && fall_i && last_bit;
        active_o   = active_q;
        mdio_o     = (!active_q || in_pre) ? 1'b1 : sh_q[31];
        mdio_oe    = active_q && !(is_rd_q && !in_pre && (idx_q >= TA_IDX));
        cap_data_o = cap_q;
        cap_err_o  = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            pre_left_q <= '0;
            idx_q      <= '0;
            sh_q       <= '0;
            is_rd_q    <= 1'b0;
            cap_q      <= '0;
            err_q      <= 1'b0;
        end else if (start_i) begin
            active_q   <= 1'b1;
            pre_left_q <= req_i.no_pre ? '0 : PRE_W'(PRE_LEN);
            idx_q      <= '0;
            sh_q       <= build_word(req_i.kind, req_i.port, req_i.mmd, req_i.payload);
            is_rd_q    <= (req_i.kind == FK_READ);
            cap_q      <= '0;
            err_q      <= 1'b0;
        end else if (active_q) begin
            if (fall_i) begin
                if (in_pre) begin
                    pre_left_q <= pre_left_q - 1'b1;
                end else if (last_bit) begin
                    active_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[30:0], 1'b1};
                end
            end
            if (rise_i && is_rd_q && !in_pre) begin
                if (idx_q == ACK_IDX) begin
                    err_q <= mdio_i;
                end else if (idx_q >= DAT_IDX) begin
                    cap_q <= {cap_q[14:0], mdio_i};
                end
            end
        end
    end
endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
    import mdio45_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             done_i,
    input  logic [15:0]      cap_data_i,
    input  logic             cap_err_i,
    output logic             start_o,
    output frame_req_t       req_o,
    output logic [DIV_W-1:0] div_o,
    output logic             addr_busy_o,
    output logic             rw_busy_o,
    output logic             rd_err_o
);
    logic [DIV_W-1:0] div_q;
    logic [15:0]      ctrl_q;
    logic [15:0]      data_q;
    logic [15:0]      addr_q;
    logic             abusy_q;
    logic             rbusy_q;
    logic             err_q;
    frame_kind_e      kind_q;

    logic any_busy;
    logic sel_stat, sel_ctrl, sel_data, sel_addr;
    logic go_addr, go_wr, go_rd, ctrl_we;
    logic unused_bits;

    assign unused_bits = ^reg_wdata[31:16];

    always_comb begin
        any_busy = abusy_q | rbusy_q;
        sel_stat = (reg_addr == OFS_STAT);
        sel_ctrl = (reg_addr == OFS_CTRL);
        sel_data = (reg_addr == OFS_DATA);
        sel_addr = (reg_addr == OFS_ADDR);
        go_addr  = reg_wr && sel_addr && !any_busy;
        go_wr    = reg_wr && sel_data && !any_busy;
        go_rd    = reg_wr && sel_ctrl && reg_wdata[CTL_RD_BIT] && !any_busy;
        ctrl_we  = reg_wr && sel_ctrl && !(reg_wdata[CTL_RD_BIT] && any_busy);
        start_o  = go_addr | go_wr | go_rd;

        req_o.kind    = FK_ADDR;
        req_o.no_pre  = ctrl_q[CTL_NOPRE_BIT];
        req_o.port    = ctrl_q[CTL_PORT_LSB +: 5];
        req_o.mmd     = ctrl_q[CTL_MMD_LSB +: 5];
        req_o.payload = reg_wdata[15:0];
        if (go_wr) begin
            req_o.kind = FK_WRITE;
        end
        if (go_rd) begin
            req_o.kind    = FK_READ;
            req_o.no_pre  = reg_wdata[CTL_NOPRE_BIT];
            req_o.port    = reg_wdata[CTL_PORT_LSB +: 5];
            req_o.mmd     = reg_wdata[CTL_MMD_LSB +: 5];
            req_o.payload = '1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_stat) begin
            reg_rdata[STAT_DIV_LSB +: DIV_W] = div_q;
            reg_rdata[STAT_ERR_BIT]          = err_q;
            reg_rdata[STAT_BUSY_BIT]         = abusy_q;
        end else if (sel_ctrl) begin
            reg_rdata[15:0] = ctrl_q;
        end else if (sel_data) begin
            reg_rdata[15:0]          = data_q;
            reg_rdata[DATA_BUSY_BIT] = rbusy_q;
        end else if (sel_addr) begin
            reg_rdata[15:0] = addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            ctrl_q  <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            abusy_q <= 1'b0;
            rbusy_q <= 1'b0;
            err_q   <= 1'b0;
            kind_q  <= FK_ADDR;
        end else begin
            if (reg_wr && sel_stat) begin
                div_q <= reg_wdata[STAT_DIV_LSB +: DIV_W];
            end
            if (ctrl_we) begin
                ctrl_q <= reg_wdata[15:0] & CTL_KEEP_MASK;
            end
            if (go_addr) begin
                addr_q  <= reg_wdata[15:0];
                abusy_q <= 1'b1;
            end
            if (go_wr) begin
                data_q  <= reg_wdata[15:0];
                rbusy_q <= 1'b1;
            end
            if (go_rd) begin
                rbusy_q <= 1'b1;
            end
            if (start_o) begin
                kind_q <= req_o.kind;
            end
            if (done_i) begin
                abusy_q <= 1'b0;
                rbusy_q <= 1'b0;
                if (kind_q == FK_READ) begin
                    err_q <= cap_err_i;
                    if (!cap_err_i) begin
                        data_q <= cap_data_i;
                    end
                end
            end
        end
    end

    always_comb begin
        div_o       = div_q;
        addr_busy_o = abusy_q;
        rw_busy_o   = rbusy_q;
        rd_err_o    = err_q;
    end
endmodule

// File: rtl/mdio45_ctrl.sv
module mdio45_ctrl
    import mdio45_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    frame_req_t       req;
    logic             start;
    logic [DIV_W-1:0] div;
    logic             addr_busy;
    logic             rw_busy;
    logic             rd_err;
    logic             active;
    logic             rise;
    logic             fall;
    logic             done;
    logic [15:0]      cap_data;
    logic             cap_err;

    mdio45_regs #(.DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .done_i      (done),
        .cap_data_i  (cap_data),
        .cap_err_i   (cap_err),
        .start_o     (start),
        .req_o       (req),
        .div_o       (div),
        .addr_busy_o (addr_busy),
        .rw_busy_o   (rw_busy),
        .rd_err_o    (rd_err)
    );

    mdio45_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (active),
        .half_cfg (div),
        .mdc      (mdc),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    mdio45_serdes #(.PRE_LEN(PRE_LEN)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .req_i      (req),
        .rise_i     (rise),
        .fall_i     (fall),
        .mdio_i     (mdio_i),
        .active_o   (active),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done_o     (done),
        .cap_data_o (cap_data),
        .cap_err_o  (cap_err)
    );
endmodule

// File: rtl/mdio45_ctrl_chk.sv
module mdio45_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic addr_busy,
    input logic rw_busy,
    input logic rd_err
);
    // R8: wire is only updated on the MDC falling edge
    a_r8_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R1: no clock and no drive without a frame in flight
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(addr_busy || rw_busy) |-> (!mdc && !mdio_oe));

    // R9: a single frame at a time
    a_r9_one_busy: assert property (@(posedge clk) disable iff (rst)
        !(addr_busy && rw_busy));

    // R3: address frame ends after a falling MDC edge
    a_r3_end_low: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_busy) |-> !mdc);

    // R7: error flag only rises at the end of a data-register frame
    a_r7_err_after_rw: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_err) |-> $past(rw_busy));
endmodule

bind mdio45_ctrl mdio45_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .addr_busy (addr_busy),
    .rw_busy   (rw_busy),
    .rd_err    (rd_err)
);

// File: tb/tb_mdio45_ctrl.sv
module tb_mdio45_ctrl;
    localparam logic [5:0] A_STAT = 6'h30;
    localparam logic [5:0] A_CTRL = 6'h34;
    localparam logic [5:0] A_DATA = 6'h38;
    localparam logic [5:0] A_ADDR = 6'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio45_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // PHY model: records each bit at MDC rise, drives replies after MDC fall
    int          nrise = 0;
    logic        rec_o  [128];
    logic        rec_oe [128];
    int          phy_pre = 32;
    bit          phy_ack = 1'b1;
    logic [15:0] phy_resp = '0;

    always @(posedge mdc) begin
        if (nrise < 128) begin
            rec_o[nrise]  = mdio_o;
            rec_oe[nrise] = mdio_oe;
        end
        nrise++;
    end

    function automatic logic phy_bit(int k);
        int pos = k - phy_pre;
        if (pos == 15) return phy_ack ? 1'b0 : 1'b1;
        if (pos >= 16 && pos <= 31 && phy_ack) return phy_resp[31-pos];
        return 1'b1;
    endfunction

    always @(negedge mdc) mdio_i = phy_bit(nrise);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // kind: 0 address, 1 write, 2 read
    task automatic run_frame(input int kind, input logic [4:0] port, input logic [4:0] dev,
                             input logic [15:0] pay, input bit nopre, input logic [7:0] div,
                             input bit ack);
        int          h = (div == 0) ? 1 : int'(div);
        int          n = nopre ? 32 : 64;
        int          cyc = 0;
        int          bad = -1;
        logic [31:0] ctl, v, old, w;
        logic [1:0]  op;
        logic [5:0]  breg;
        int          bpos;
        string       tag;
        op   = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : 2'b11;
        tag  = (kind == 0) ? "R3" : (kind == 1) ? "R5" : "R6";
        ctl  = (32'(nopre) << 10) | (32'(port) << 5) | 32'(dev);
        breg = (kind == 0) ? A_STAT : A_DATA;
        bpos = (kind == 0) ? 0 : 31;
        wr(A_STAT, {16'h0, div, 8'h0});
        wr(A_CTRL, ctl);
        rd(A_DATA, old);
        phy_pre  = n - 32;
        phy_ack  = ack;
        phy_resp = pay;
        nrise    = 0;
        mdio_i   = 1'b1;
        case (kind)
            0: wr(A_ADDR, {16'h0, pay});
            1: wr(A_DATA, {16'h0, pay});
            default: wr(A_CTRL, ctl | 32'h8000);
        endcase
        forever begin
            rd(breg, v);
            if (!v[bpos] || cyc > 100000) break;
            cyc++;
            @(negedge clk);
        end
        // R8: busy length follows 2*H*N
        chk(cyc == 2 * h * n, tag, cyc, 2 * h * n);
        chk(nrise == n, "R4", nrise, n);
        w = {2'b00, op, port, dev, 2'b10, pay};
        for (int k = 0; k < n; k++) begin
            int   pos = k - (n - 32);
            logic eoe, eo;
            if (pos < 0) begin eoe = 1'b1; eo = 1'b1; end
            else if (kind == 2 && pos >= 14) begin eoe = 1'b0; eo = 1'b0; end
            else begin eoe = 1'b1; eo = w[31-pos]; end
            if (bad < 0 && (rec_oe[k] !== eoe || (eoe && rec_o[k] !== eo))) bad = k;
        end
        chk(bad < 0, (kind == 2) ? "R6 bit order" : "R4 bit order", bad, 32'hFFFF_FFFF);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle after frame", {mdc, mdio_oe}, 0);
        case (kind)
            0: begin rd(A_ADDR, v); chk(v == {16'h0, pay}, "R3 address held", v, {16'h0, pay}); end
            1: begin rd(A_DATA, v); chk(v == {16'h0, pay}, "R5 data held", v, {16'h0, pay}); end
            default: begin
                if (ack) begin
                    rd(A_DATA, v); chk(v == {16'h0, pay}, "R6 captured", v, {16'h0, pay});
                    rd(A_STAT, v); chk(v[1] == 1'b0, "R7 error clear", v, {16'h0, div, 8'h0});
                end else begin
                    rd(A_DATA, v); chk(v == old, "R7 data kept", v, old);
                    rd(A_STAT, v); chk(v[1] == 1'b1, "R7 error set", v, {16'h0, div, 8'h2});
                end
            end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, ctl0, dat0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R1 control", v, 0);
        rd(A_DATA, v); chk(v == 0, "R1 data", v, 0);
        rd(A_ADDR, v); chk(v == 0, "R1 address", v, 0);
        rd(6'h00, v);  chk(v == 0, "R1 unmapped", v, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 bus idle", {mdc, mdio_oe}, 0);

        // R2: field masks
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk(v == 32'h0000_FF00, "R2 status fields", v, 32'h0000_FF00);
        wr(A_CTRL, 32'hFFFF_7FFF);
        rd(A_CTRL, v); chk(v == 32'h0000_4FFF, "R2 control fields", v, 32'h0000_4FFF);
        chk(mdc == 1'b0, "R2 no frame from control", mdc, 0);

        // Sweep: divider x preamble x frame type
        for (int dv = 0; dv < 4; dv++)
            for (int np = 0; np < 2; np++)
                for (int kd = 0; kd < 3; kd++)
                    run_frame(kd, 5'(dv * 9 + np * 5 + kd + 1), 5'(dv * 3 + kd * 7 + np),
                              16'(32'hA5C3 ^ (dv * 32'h1111) ^ (kd << 3) ^ np),
                              np[0], 8'(dv), 1'b1);
        run_frame(1, 5'd31, 5'd31, 16'hFFFF, 1'b1, 8'd5, 1'b1);
        run_frame(0, 5'd0, 5'd0, 16'h0000, 1'b1, 8'd5, 1'b1);

        // R7: missing acknowledge, then recovery
        run_frame(1, 5'd7, 5'd30, 16'h3C3C, 1'b1, 8'd1, 1'b1);
        run_frame(2, 5'd7, 5'd30, 16'h0F0F, 1'b0, 8'd2, 1'b0);
        run_frame(2, 5'd7, 5'd30, 16'hCAFE, 1'b1, 8'd2, 1'b1);

        // R9: start writes during a busy frame are dropped
        wr(A_STAT, 32'h0000_0100);
        ctl0 = 32'h0000_0061;
        wr(A_CTRL, ctl0);
        rd(A_DATA, dat0);
        nrise = 0; phy_pre = 32; phy_ack = 1'b1; mdio_i = 1'b1;
        wr(A_ADDR, 32'h0000_1234);
        repeat (10) @(negedge clk);
        wr(A_ADDR, 32'h0000_BEEF);
        wr(A_DATA, 32'h0000_5555);
        wr(A_CTRL, 32'h0000_8000 | 32'h0000_03E0);
        repeat (400) @(negedge clk);
        chk(nrise == 64, "R9 single frame", nrise, 64);
        rd(A_ADDR, v); chk(v == 32'h0000_1234, "R9 address kept", v, 32'h0000_1234);
        rd(A_DATA, v); chk(v == dat0, "R9 data kept", v, dat0);
        rd(A_CTRL, v); chk(v == ctl0, "R9 control kept", v, ctl0);
        rd(A_STAT, v); chk(v == 32'h0000_0100, "R9 no busy left", v, 32'h0000_0100);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 quiet after frames", {mdc, mdio_oe}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule